// File: doc/BRIEF.md
# Offset-Aligned Pulse-Width Channel

This block is a single pulse-width-modulation lane. A free-running counter steps from 1 up to the programmed period and then wraps. Each period opens with the high part of the pulse, and the output stays high for the first `width` counts. The period, width and offset are all given in clock cycles, so the duty cycle is width over period. A period of zero switches the lane off.

The lane's phase comes from a counter that several lanes share and that an outside controller drives. When the controller asks for a realignment, the lane takes in a fresh period, width and offset. It parks with its output low and its counter at 1 until the shared count equals its own offset, and then it begins a new period. The request can be forced or gentle. A forced request cuts the running pulse short at once. A gentle request lets the running period finish with the old settings and realigns at its boundary. The lane flags the last count of every period so that the controller can time gentle realignments.

Top module: `pwm_align_channel`

## Requirements
- R1: Out of reset the channel is disabled (period 0): `pwm_out` and `period_done` are both low.
- R2: While running with period P > 0, the count takes the values 1, 2, ..., P and then goes back to 1, one step per clock. `pwm_out` is high exactly when the count is at most the width.
- R3: A width greater than or equal to the period holds `pwm_out` high on every running cycle. A width of 0 holds it low.
- R4: With an active period of 0, `pwm_out` and `period_done` stay low.
- R5: `period_done` is high for one cycle, the cycle in which the count equals the period, and only while the lane runs with a nonzero period.
- R6: A forced request (`align_req`=1 with `align_force`=1) loads the `cfg_*` inputs at that edge and moves the lane into waiting. While waiting, the count is 1 and both outputs are low. A request made while already waiting also relatches the `cfg_*` inputs. The first cycle of the new period is the cycle after the one in which `offset_cnt` equals the loaded offset.
- R7: A gentle request (`align_req`=1 with `align_force`=0) made while a period is running is stored. The lane keeps its old settings until the cycle in which the count equals the old period. At that edge it loads the stored values and enters waiting. A forced request made meanwhile takes priority.
- R8: A gentle request acts as a forced one when the lane is waiting, when it is disabled, or when it arrives on the last count of a period.
- R9: Without a request, changes on `cfg_period`, `cfg_width` and `cfg_offset` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | 16 | New period in cycles, 0 disables |
| cfg_width | input | 16 | New high time in cycles |
| cfg_offset | input | 16 | New phase offset, compared to `offset_cnt` |
| align_req | input | 1 | Realignment request, one cycle |
| align_force | input | 1 | 1: abrupt restart, 0: restart at period end |
| offset_cnt | input | 16 | Shared phase counter value from the controller |
| pwm_out | output | 1 | Pulse output |
| period_done | output | 1 | High on the last count of each period |

## Verification
On every cycle, the assertions check the following: the count stays in range, a disabled lane stays silent, a full-width pulse stays high, a waiting lane is low with its count held at 1, the end-of-period flag lasts a single cycle, and the active settings move only on a request or a pending commit. Only the bench scenarios can show the exact pulse shape and the cycle in which a period starts relative to the shared counter. They also show that a gentle request waits for the old period to finish, and that a request on the last count or in the idle state takes effect at once. The bench sweeps every period up to 5, every width up to 6 and every offset up to 3, and predicts each cycle arithmetically.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    parameter int unsigned CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_ZERO = '0;
    localparam cnt_t CNT_ONE  = cnt_t'(1);

    typedef struct packed {
        cnt_t period;
        cnt_t width;
        cnt_t offset;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAIT  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_INPUT  = 2'd1,
        LD_SHADOW = 2'd2
    } load_sel_e;

    function automatic cnt_t step_count(cnt_t cur, cnt_t per);
        return (cur >= per) ? CNT_ONE : cur + CNT_ONE;
    endfunction

    function automatic logic is_last(cnt_t cur, cnt_t per);
        return (per != CNT_ZERO) && (cur == per);
    endfunction

endpackage

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
    import pwm_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      shadow_we,
    input  chan_cfg_t cfg_in,
    input  load_sel_e load_sel,
    output chan_cfg_t active_cfg
);

    chan_cfg_t shadow_q;
    chan_cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (shadow_we) begin
            shadow_q <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else begin
            case (load_sel)
                LD_INPUT:  active_q <= cfg_in;
                LD_SHADOW: active_q <= shadow_q;
                default:   active_q <= active_q;
            endcase
        end
    end

    assign active_cfg = active_q;

endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
    import pwm_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      align_req,
    input  logic      align_force,
    input  logic      last_cnt,
    input  logic      disabled,
    input  logic      offset_hit,
    output phase_e    phase_q,
    output load_sel_e load_sel,
    output logic      cnt_clear
);

    phase_e state_q;
    phase_e state_n;

    always_comb begin
        state_n  = state_q;
        load_sel = LD_NONE;
        case (state_q)
            ST_WAIT: begin
                if (align_req) begin
                    load_sel = LD_INPUT;
                end else if (offset_hit) begin
                    state_n = ST_RUN;
                end
            end
            ST_RUN, ST_ARMED: begin
                if (align_req && (align_force || disabled || last_cnt)) begin
                    load_sel = LD_INPUT;
                    state_n  = ST_WAIT;
                end else if (align_req) begin
                    state_n = ST_ARMED;
                end else if ((state_q == ST_ARMED) && (last_cnt || disabled)) begin
                    load_sel = LD_SHADOW;
                    state_n  = ST_WAIT;
                end
            end
            default: begin
                state_n = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_n;
        end
    end

    assign cnt_clear = (state_n == ST_WAIT) || (state_q == ST_WAIT);
    assign phase_q   = state_q;

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
    import pwm_chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic running,
    input  cnt_t period,
    input  cnt_t width,
    output cnt_t cnt_q,
    output logic pwm_out,
    output logic period_done
);

    cnt_t cnt_r;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_r <= CNT_ONE;
        end else if (period != CNT_ZERO) begin
            cnt_r <= step_count(cnt_r, period);
        end
    end

    assign cnt_q       = cnt_r;
    assign period_done = running && is_last(cnt_r, period);
    assign pwm_out     = running && (period != CNT_ZERO) && (cnt_r <= width);

endmodule

// File: rtl/pwm_align_channel.sv
module pwm_align_channel
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_offset,
    input  logic             align_req,
    input  logic             align_force,
    input  logic [CNT_W-1:0] offset_cnt,
    output logic             pwm_out,
    output logic             period_done
);

    chan_cfg_t cfg_in;
    chan_cfg_t active_cfg;
    load_sel_e load_sel;
    phase_e    phase_q;
    cnt_t      cnt_q;
    logic      cnt_clear;
    logic      running;
    logic      offset_hit;
    logic      disabled;

    assign cfg_in     = '{period: cfg_period, width: cfg_width, offset: cfg_offset};
    assign running    = (phase_q != ST_WAIT);
    assign disabled   = (active_cfg.period == CNT_ZERO);
    assign offset_hit = (offset_cnt == active_cfg.offset);

    pwm_cfg_bank bank_i (
        .clk        (clk),
        .rst        (rst),
        .shadow_we  (align_req),
        .cfg_in     (cfg_in),
        .load_sel   (load_sel),
        .active_cfg (active_cfg)
    );

    pwm_phase_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .align_req   (align_req),
        .align_force (align_force),
        .last_cnt    (period_done),
        .disabled    (disabled),
        .offset_hit  (offset_hit),
        .phase_q     (phase_q),
        .load_sel    (load_sel),
        .cnt_clear   (cnt_clear)
    );

    pwm_period_counter cnt_i (
        .clk         (clk),
        .rst         (rst),
        .clear       (cnt_clear),
        .running     (running),
        .period      (active_cfg.period),
        .width       (active_cfg.width),
        .cnt_q       (cnt_q),
        .pwm_out     (pwm_out),
        .period_done (period_done)
    );

endmodule

// File: rtl/pwm_align_channel_chk.sv
module pwm_align_channel_chk
    import pwm_chan_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input phase_e    phase_q,
    input cnt_t      cnt_q,
    input chan_cfg_t active_cfg,
    input logic      align_req,
    input logic      pwm_out,
    input logic      period_done
);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != CNT_ZERO) && ((active_cfg.period == CNT_ZERO) || (cnt_q <= active_cfg.period)));

    assert_full_width_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q != ST_WAIT) && (active_cfg.period != CNT_ZERO) &&
        (active_cfg.width >= active_cfg.period) |-> pwm_out);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (active_cfg.period == CNT_ZERO) |-> (!pwm_out && !period_done));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        period_done && (active_cfg.period > CNT_ONE) |=> !period_done);

    assert_wait_low_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_WAIT) |-> (!pwm_out && !period_done && (cnt_q == CNT_ONE)));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!align_req && (phase_q != ST_ARMED)) |=> $stable(active_cfg));

endmodule

bind pwm_align_channel pwm_align_channel_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .phase_q     (phase_q),
    .cnt_q       (cnt_q),
    .active_cfg  (active_cfg),
    .align_req   (align_req),
    .pwm_out     (pwm_out),
    .period_done (period_done)
);

// File: tb/pwm_align_channel_tb.sv
`timescale 1ns/1ps
module pwm_align_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_period = '0;
    logic [15:0] cfg_width  = '0;
    logic [15:0] cfg_offset = '0;
    logic        align_req   = 1'b0;
    logic        align_force = 1'b0;
    logic        oc_clr      = 1'b0;
    logic [15:0] offset_cnt  = '0;
    logic        pwm_out;
    logic        period_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        offset_cnt <= oc_clr ? 16'd0 : offset_cnt + 16'd1;
    end

    pwm_align_channel dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_period  (cfg_period),
        .cfg_width   (cfg_width),
        .cfg_offset  (cfg_offset),
        .align_req   (align_req),
        .align_force (align_force),
        .offset_cnt  (offset_cnt),
        .pwm_out     (pwm_out),
        .period_done (period_done)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        align_req   = 1'b0;
        align_force = 1'b0;
        oc_clr      = 1'b0;
    endtask

    task automatic do_align(input int p, input int w, input int o, input logic force_it);
        cfg_period  = 16'(p);
        cfg_width   = 16'(w);
        cfg_offset  = 16'(o);
        align_req   = 1'b1;
        align_force = force_it;
        oc_clr      = 1'b1;
        tick();
    endtask

    // Cycle j counts from the cycle after the realignment edge; offset_cnt equals j there.
    task automatic run_check(input int p, input int w, input int o, input int n, input string ovr);
        for (int j = 0; j < n; j++) begin
            logic ep;
            logic ed;
            string tp;
            string td;
            int c;
            ep = 1'b0;
            ed = 1'b0;
            tp = "R2";
            td = "R5";
            if (j <= o) begin
                tp = "R6";
                td = "R6";
            end else if (p == 0) begin
                tp = "R4";
                td = "R4";
            end else begin
                c  = ((j - o - 1) % p) + 1;
                ep = (c <= w);
                ed = (c == p);
                if (w >= p || w == 0) tp = "R3";
            end
            if (ovr != "") begin
                tp = ovr;
                td = ovr;
            end
            check(pwm_out, ep, tp, "pwm_out");
            check(period_done, ed, td, "period_done");
            cfg_period = 16'hFFFF - 16'(j);
            cfg_width  = 16'(j * 3);
            cfg_offset = 16'(j + 7);
            tick();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pwm_out, 1'b0, "R1", "pwm_out in reset");
        check(period_done, 1'b0, "R1", "period_done in reset");
        rst = 1'b0;
        tick();
        check(pwm_out, 1'b0, "R1", "pwm_out after reset");
        check(period_done, 1'b0, "R1", "period_done after reset");

        // R8: gentle request while disabled acts at once
        do_align(4, 1, 1, 1'b0);
        run_check(4, 1, 1, 10, "R8");

        // R2 R3 R4 R5 R6: forced sweep over small configurations
        for (int p = 0; p <= 5; p++) begin
            for (int w = 0; w <= 6; w++) begin
                for (int o = 0; o <= 3; o++) begin
                    do_align(p, w, o, 1'b1);
                    run_check(p, w, o, o + 2 * p + 3, "");
                end
            end
        end

        // R7: gentle request mid-period defers to the old period end
        do_align(5, 2, 0, 1'b1);
        run_check(5, 2, 0, 4, "");
        check(pwm_out, 1'b0, "R7", "pwm_out cnt4 old cfg");
        check(period_done, 1'b0, "R7", "period_done cnt4");
        cfg_period = 16'd3; cfg_width = 16'd1; cfg_offset = 16'd2;
        align_req = 1'b1; align_force = 1'b0;
        tick();
        check(pwm_out, 1'b0, "R7", "pwm_out cnt5 old cfg");
        check(period_done, 1'b1, "R7", "period_done old period end");
        cfg_period = 16'd9; cfg_width = 16'd9; cfg_offset = 16'd9;
        oc_clr = 1'b1;
        tick();
        run_check(3, 1, 2, 12, "R7");

        // R7: forced request overrides a pending gentle one
        do_align(4, 2, 0, 1'b1);
        run_check(4, 2, 0, 3, "");
        cfg_period = 16'd2; cfg_width = 16'd1; cfg_offset = 16'd1;
        align_req = 1'b1; align_force = 1'b0;
        tick();
        check(pwm_out, 1'b0, "R7", "pwm_out armed cnt4");
        check(period_done, 1'b1, "R7", "period_done armed cnt4");
        do_align(3, 3, 0, 1'b1);
        run_check(3, 3, 0, 9, "R7");

        // R8: gentle request on the last count acts at once
        do_align(3, 1, 0, 1'b1);
        run_check(3, 1, 0, 3, "");
        check(period_done, 1'b1, "R8", "period_done last count");
        do_align(2, 2, 1, 1'b0);
        run_check(2, 2, 1, 8, "R8");

        // R8: gentle request while waiting relatches at once
        do_align(5, 1, 3, 1'b1);
        run_check(5, 1, 3, 2, "");
        do_align(2, 1, 0, 1'b0);
        run_check(2, 1, 0, 6, "R8");

        // R9: config inputs wiggle without a request
        do_align(4, 3, 1, 1'b1);
        run_check(4, 3, 1, 14, "R9");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule